// File: doc/BRIEF.md
# Register-Pair Add/Subtract Flag Unit

This unit does the 16-bit register-pair arithmetic of an 8-bit processor's datapath. It has three operations: plain add, add with carry, and subtract with borrow. The caller presents four inputs:

- a destination value;
- an operand;
- the current flag byte;
- an operation code.

The unit works out the new 16-bit value and the new flag byte. Both are captured in output registers on a strobe, and they hold until the next accepted strobe or a reset.

Plain add changes only part of the flag byte. The sign, zero and parity/overflow flags pass through unchanged, and the other flags are rebuilt. The carry-using operations rebuild the whole flag byte. For every operation, the half-carry flag shows the carry or borrow into bit 12. The two spare flag bits copy bits 13 and 11 of the result.

Top module: `pair_arith_flags`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and `flags_out` to zero at the next rising clock edge, and reset takes priority over `strobe`.
- R2: When `strobe` is low, `result` and `flags_out` keep their values.
- R3: The operation codes are 2'b00 plain add, 2'b01 add with carry and 2'b10 subtract with borrow. A strobe with code 2'b11 leaves both outputs unchanged.
- R4: The flag byte layout is S bit 7, Z bit 6, spare bit 5, H bit 4, spare bit 3, P/V bit 2, N bit 1, C bit 0. The incoming carry is `flags_in[0]`.
- R5: `result` is the low 16 bits of dst+src (plain add), dst+src+C (add with carry) or dst-src-C (subtract with borrow).
- R6: C is set exactly when the exact sum or difference lies outside 0..0xFFFF.
- R7: H equals bit 12 of (dst XOR src XOR result) for all three operations.
- R8: Plain add copies S, Z and P/V from `flags_in` and clears N.
- R9: For add with carry and subtract with borrow, S equals result bit 15 and Z is set exactly when the result is zero.
- R10: Add with carry sets P/V when dst and src have equal sign bits and the result's sign differs from dst's. It also clears N.
- R11: Subtract with borrow sets P/V when dst and src differ in sign and the result's sign differs from dst's. It also sets N.
- R12: For every operation, spare flag bit 5 copies result bit 13 and spare flag bit 3 copies result bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Capture the computed result and flags |
| op | input | 2 | Operation code |
| dst | input | 16 | Destination register-pair value |
| src | input | 16 | Operand value |
| flags_in | input | 8 | Current flag byte |
| result | output | 16 | Registered 16-bit result |
| flags_out | output | 8 | Registered flag byte |

## Verification
The bench builds the unit at its default width of 16 bits. At that width the flag positions match the processor layout: sign at bit 15, half-carry at bit 12, spare bits at 13 and 11. The directed vectors cover these cases:

- the carry-out and borrow wrap points at 0xFFFF and 0x0000;
- the signed limits 0x7FFF and 0x8000 for both overflow rules;
- a zero result reached only through the incoming carry.

A seeded random sweep then mixes all four codes with random strobes and resets. Each cycle is compared against an integer model.

// File: rtl/pair_arith_flags.sv
module pair_arith_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [1:0]   op,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic [7:0]   flags_in,
  output logic [W-1:0] result,
  output logic [7:0]   flags_out
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_ADC = 2'b01;
  localparam logic [1:0] OP_SBC = 2'b10;
  localparam int SGN = W - 1;
  localparam int HCB = W - 4;
  localparam int X5B = W - 3;
  localparam int X3B = W - 5;

  logic         cin;
  logic         is_sub;
  logic         cadd;
  logic [W:0]   wide;
  logic [W-1:0] res;
  logic         hc, v_add, v_sub, zf;
  logic [7:0]   fnext;

  assign cin    = flags_in[0];
  assign is_sub = (op == OP_SBC);
  assign cadd   = (op == OP_ADC) & cin;

  assign wide = is_sub ? ({1'b0, dst} - {1'b0, src} - {{W{1'b0}}, cin})
                       : ({1'b0, dst} + {1'b0, src} + {{W{1'b0}}, cadd});
  assign res  = wide[W-1:0];

  assign hc    = dst[HCB] ^ src[HCB] ^ res[HCB];
  assign zf    = (res == '0);
  assign v_add = (dst[SGN] == src[SGN]) & (res[SGN] != dst[SGN]);
  assign v_sub = (dst[SGN] != src[SGN]) & (res[SGN] != dst[SGN]);

  always_comb begin
    fnext = 8'h00;
    fnext[5] = res[X5B];
    fnext[3] = res[X3B];
    fnext[4] = hc;
    fnext[0] = wide[W];
    case (op)
      OP_ADD: begin
        fnext[7] = flags_in[7];
        fnext[6] = flags_in[6];
        fnext[2] = flags_in[2];
      end
      OP_ADC: begin
        fnext[7] = res[SGN];
        fnext[6] = zf;
        fnext[2] = v_add;
      end
      default: begin
        fnext[7] = res[SGN];
        fnext[6] = zf;
        fnext[2] = v_sub;
        fnext[1] = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= 8'h00;
    end else if (strobe && op != 2'b11) begin
      result    <= res;
      flags_out <= fnext;
    end
  end
endmodule

// File: rtl/pair_arith_flags_chk.sv
module pair_arith_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         strobe,
  input logic [1:0]   op,
  input logic [W-1:0] dst,
  input logic [W-1:0] src,
  input logic [7:0]   flags_in,
  input logic [W-1:0] result,
  input logic [7:0]   flags_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && flags_out == 8'h00));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(result) && $stable(flags_out)));

  // R3
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == 2'b11) |=> ($stable(result) && $stable(flags_out)));

  // R8
  add_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == 2'b00) |=> (flags_out[7] == $past(flags_in[7]) &&
      flags_out[6] == $past(flags_in[6]) && flags_out[2] == $past(flags_in[2]) &&
      !flags_out[1]));

  // R9
  sign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && (op == 2'b01 || op == 2'b10)) |=>
      (flags_out[7] == result[W-1] && flags_out[6] == (result == '0)));

  // R10
  adc_n_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == 2'b01) |=> !flags_out[1]);

  // R11
  sbc_n_set_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == 2'b10) |=> flags_out[1]);

  // R12
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && op != 2'b11) |=>
      (flags_out[5] == result[W-3] && flags_out[3] == result[W-5]));
endmodule

bind pair_arith_flags pair_arith_flags_chk #(.W(W)) chk_i (.*);

// File: tb/pair_arith_flags_test.sv
`timescale 1ns/1ps
module pair_arith_flags_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] dst = '0, src = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] result;
  logic [7:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int exp_res = 0;
  int exp_flg = 0;

  always #5 clk = ~clk;

  pair_arith_flags uut (.clk(clk), .rst(rst), .strobe(strobe), .op(op),
    .dst(dst), .src(src), .flags_in(flags_in), .result(result), .flags_out(flags_out));

  task automatic model(input int o, input int d, input int s, input int f);
    int c, w, r, fl;
    c = f & 1;
    if (o == 0)      w = d + s;
    else if (o == 1) w = d + s + c;
    else             w = d - s - c;
    r = w & 'hFFFF;
    fl = (r >> 8) & 'h28;
    if (w > 'hFFFF || w < 0) fl |= 'h01;
    if (((d ^ s ^ r) >> 12) & 1) fl |= 'h10;
    if (o == 0) fl |= f & 'hC4;
    else begin
      if (r & 'h8000) fl |= 'h80;
      if (r == 0) fl |= 'h40;
      if (o == 1 && ((d ^ s) & 'h8000) == 0 && ((d ^ r) & 'h8000) != 0) fl |= 'h04;
      if (o == 2 && ((d ^ s) & 'h8000) != 0 && ((d ^ r) & 'h8000) != 0) fl |= 'h04;
      if (o == 2) fl |= 'h02;
    end
    exp_res = r;
    exp_flg = fl;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(result) != exp_res || int'(flags_out) != exp_flg) begin
      fails++;
      $display("FAIL %s: result=%04h flags=%02h expected result=%04h flags=%02h",
               tag, result, flags_out, exp_res[15:0], exp_flg[7:0]);
    end
  endtask

  task automatic step(input bit r, input bit st, input int o, input int d,
                      input int s, input int f, input string tag);
    rst = r; strobe = st; op = o[1:0]; dst = d[15:0]; src = s[15:0]; flags_in = f[7:0];
    if (r) begin exp_res = 0; exp_flg = 0; end
    else if (st && o != 3) model(o, d, s, f);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 0, 'h1234, 'h1111, 'hFF, "R1 reset");
    step(0, 1, 0, 'hFFFF, 'h0001, 'hC4, "R6 R8 add wrap keeps SZV");
    step(0, 1, 0, 'h0FFF, 'h0001, 'h00, "R7 add half carry");
    step(0, 1, 0, 'h2800, 'h0000, 'h3B, "R12 R8 add spare bits");
    step(0, 0, 1, 'h5555, 'h5555, 'h00, "R2 no strobe hold");
    step(0, 1, 3, 'h0001, 'h0001, 'h00, "R3 reserved code hold");
    step(0, 1, 1, 'h7FFF, 'h0001, 'h00, "R10 adc overflow");
    step(0, 1, 1, 'hFFFF, 'h0000, 'h01, "R9 R6 adc zero by carry");
    step(0, 1, 1, 'h8000, 'h8000, 'h00, "R10 adc negative overflow");
    step(0, 1, 1, 'h1234, 'h0101, 'h01, "R5 adc plain");
    step(0, 1, 2, 'h0000, 'h0001, 'h00, "R11 R6 sbc borrow");
    step(0, 1, 2, 'h8000, 'h0001, 'h00, "R11 sbc overflow");
    step(0, 1, 2, 'h4321, 'h4320, 'h01, "R9 sbc zero with borrow");
    step(0, 1, 2, 'h1000, 'h0001, 'h00, "R7 sbc half borrow");
    step(1, 1, 1, 'hAAAA, 'h5555, 'h01, "R1 reset over strobe");
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 29) == 0, ($urandom % 4) != 0, $urandom % 4,
           $urandom % 65536, $urandom % 65536, $urandom % 256, "R4 R5 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule